// File: doc/BRIEF.md
# Vector-Element Lane Multiplier

This block is the multiply stage of a 128-lane vector datapath. Each cycle it takes an operation code, a multiplicand vector (chosen from two vector registers or a memory-bypass input), a wide cyclic operand register of 512 signed bytes, a mask register and a set of scalar sources. From these it forms 128 signed 32-bit products. The product vector is registered once and goes straight to the accumulate stage. It is valid for exactly one cycle for each operation.

There are three kinds of multiply. The element-wise kind pairs lane i of the multiplicand with a cyclic element and wraps around the cyclic register. The fixed-element kind multiplies one chosen multiplicand element against a window of cyclic elements. The scalar kind multiplies the low byte of a control register or of an activation register against that same window. The window does not wrap: lanes that fall past the last cyclic element use the value one. A per-lane mask, shifted and offset, forces the products of disabled lanes to zero.

Top module: `vec_lane_mult`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `prod_valid` is 0 and `prod_vec` is all zero.
- R2: Operation codes are: 0 no-op, 1 element-wise, 2 fixed-element, 3 scalar from control register, 4 scalar from activation register, and 5 to 7 act as no-op. An operation presented at one clock edge sets `prod_valid` high after that edge for exactly one cycle. A no-op sets it low.
- R3: Whenever `prod_valid` is low, `prod_vec` is all zero.
- R4: In element-wise mode, lane i is mcand[i] times cyc[(cyc_off + i) mod 512].
- R5: `src_sel` picks the multiplicand vector: 0 selects `r0_vec`, 1 selects `r1_vec`, and 2 or 3 select `byp_vec`.
- R6: In fixed-element mode, lane i is mcand[fix_idx] times cyc[cyc_off + i]. When cyc_off + i exceeds 511, the value one is used in place of the cyclic element.
- R7: In control-register scalar mode, the scalar is bits [7:0] of control register `cr_idx`, which occupies bits [32j+31:32j] of `cr_regs`. Lane i is that scalar times the window element, or times one past the end of the cyclic register.
- R8: In activation-register scalar mode, the scalar is bits [7:0] of activation register `aq_idx` in `aq_regs`, with the same 32-bit packing and the same windowing as R7.
- R9: Lane i is enabled only if k = mask_off + mask_shift + i is below 512 and `mask_reg[k]` is 1. A disabled lane outputs zero.
- R10: All vector elements are signed 8-bit values, with element k at bits [8k+7:8k]. Product lane i sits at bits [32i+31:32i] and is the sign-extended two's-complement product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code |
| src_sel | input | 2 | Multiplicand vector select |
| r0_vec | input | 1024 | Vector register 0 |
| r1_vec | input | 1024 | Vector register 1 |
| byp_vec | input | 1024 | Memory-bypass vector |
| cyc_reg | input | 4096 | Cyclic operand register, 512 bytes |
| cyc_off | input | 9 | Window start in the cyclic register |
| fix_idx | input | 7 | Fixed multiplicand element index |
| cr_regs | input | 512 | Sixteen 32-bit control registers |
| cr_idx | input | 4 | Control register select |
| aq_regs | input | 128 | Four 32-bit activation registers |
| aq_idx | input | 2 | Activation register select |
| mask_reg | input | 512 | Lane mask source |
| mask_off | input | 9 | Mask start offset |
| mask_shift | input | 9 | Mask right shift |
| prod_vec | output | 4096 | 128 signed 32-bit products |
| prod_valid | output | 1 | Product vector valid |

## Verification
The block holds no state apart from the output register, so a wrong internal value shows up at the ports one cycle after the operation that caused it and nowhere else. A fault in window indexing moves the products of every lane by a constant stride. A fault in the padding limit changes only the lanes near the end of the cyclic register. A mask fault zeroes the wrong lanes or leaves the right ones non-zero. The vectors are chosen so that offsets near 511, offsets that wrap, masks near their end and negative scalars each single out one of these faults.

// File: rtl/vec_lane_mult.sv
module vec_lane_mult #(
  parameter int LANES  = 128,
  parameter int CYC_N  = 512,
  parameter int EW     = 8,
  parameter int PW     = 32,
  parameter int MASK_N = 512,
  parameter int CR_N   = 16,
  parameter int AQ_N   = 4,
  parameter int RW     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    op,
  input  logic [1:0]                    src_sel,
  input  logic [LANES*EW-1:0]           r0_vec,
  input  logic [LANES*EW-1:0]           r1_vec,
  input  logic [LANES*EW-1:0]           byp_vec,
  input  logic [CYC_N*EW-1:0]           cyc_reg,
  input  logic [$clog2(CYC_N)-1:0]      cyc_off,
  input  logic [$clog2(LANES)-1:0]      fix_idx,
  input  logic [CR_N*RW-1:0]            cr_regs,
  input  logic [$clog2(CR_N)-1:0]       cr_idx,
  input  logic [AQ_N*RW-1:0]            aq_regs,
  input  logic [$clog2(AQ_N)-1:0]       aq_idx,
  input  logic [MASK_N-1:0]             mask_reg,
  input  logic [$clog2(MASK_N)-1:0]     mask_off,
  input  logic [$clog2(MASK_N)-1:0]     mask_shift,
  output logic [LANES*PW-1:0]           prod_vec,
  output logic                          prod_valid
);
  localparam int OFFW  = $clog2(CYC_N);
  localparam int MOFFW = $clog2(MASK_N);
  localparam int IXW   = OFFW + 2;
  localparam int MIXW  = MOFFW + 2;
  localparam int XW    = PW - 2*EW;

  localparam logic [2:0] OP_EE  = 3'd1;
  localparam logic [2:0] OP_VE  = 3'd2;
  localparam logic [2:0] OP_SCR = 3'd3;
  localparam logic [2:0] OP_SAQ = 3'd4;

  logic [LANES*EW-1:0] mcand;
  logic signed [EW-1:0] fixed_e, scalar;
  logic op_ok;
  logic [LANES*PW-1:0] prod_d;
  wire unused_hi = &{1'b0, cr_regs, aq_regs};

  assign mcand   = (src_sel == 2'd0) ? r0_vec : (src_sel == 2'd1) ? r1_vec : byp_vec;
  assign fixed_e = mcand[fix_idx*EW +: EW];
  assign scalar  = (op == OP_SCR) ? cr_regs[cr_idx*RW +: EW] : aq_regs[aq_idx*RW +: EW];
  assign op_ok   = (op == OP_EE) || (op == OP_VE) || (op == OP_SCR) || (op == OP_SAQ);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IXW-1:0]  lin;
    logic [MIXW-1:0] mix;
    logic            in_rng, en;
    logic signed [EW-1:0]   a, b, celem;
    logic signed [2*EW-1:0] p;

    assign lin    = IXW'(cyc_off) + IXW'(i);
    assign in_rng = lin < IXW'(CYC_N);
    assign celem  = cyc_reg[lin[OFFW-1:0]*EW +: EW];
    assign mix    = MIXW'(mask_off) + MIXW'(mask_shift) + MIXW'(i);
    assign en     = (mix < MIXW'(MASK_N)) && mask_reg[mix[MOFFW-1:0]];

    always_comb begin
      a = '0;
      b = '0;
      case (op)
        OP_EE:          begin a = mcand[i*EW +: EW]; b = celem; end
        OP_VE:          begin a = fixed_e; b = in_rng ? celem : EW'(1); end
        OP_SCR, OP_SAQ: begin a = scalar;  b = in_rng ? celem : EW'(1); end
        default:        begin a = '0; b = '0; end
      endcase
    end

    assign p = a * b;
    assign prod_d[i*PW +: PW] = en ? {{XW{p[2*EW-1]}}, p} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_valid <= 1'b0;
      prod_vec   <= '0;
    end else begin
      prod_valid <= op_ok;
      prod_vec   <= op_ok ? prod_d : '0;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> (!prod_valid && prod_vec == '0));
  a_r2_op_gives_valid: assert property (@(posedge clk) disable iff (!rst_n) op_ok |=> prod_valid);
  a_r2_nop_drops_valid: assert property (@(posedge clk) disable iff (!rst_n) !op_ok |=> !prod_valid);
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n) !prod_valid |-> prod_vec == '0);
  a_r9_empty_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_reg == '0) |=> prod_vec == '0);
endmodule

// File: tb/sim_vec_lane_mult.sv
module sim_vec_lane_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] op;
  logic [1:0] src_sel;
  logic [1023:0] r0_vec, r1_vec, byp_vec;
  logic [4095:0] cyc_reg;
  logic [8:0] cyc_off;
  logic [6:0] fix_idx;
  logic [511:0] cr_regs;
  logic [3:0] cr_idx;
  logic [127:0] aq_regs;
  logic [1:0] aq_idx;
  logic [511:0] mask_reg;
  logic [8:0] mask_off, mask_shift;
  logic [4095:0] prod_vec;
  logic prod_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  vec_lane_mult u0 (.clk, .rst_n, .op, .src_sel, .r0_vec, .r1_vec, .byp_vec, .cyc_reg,
    .cyc_off, .fix_idx, .cr_regs, .cr_idx, .aq_regs, .aq_idx, .mask_reg, .mask_off,
    .mask_shift, .prod_vec, .prod_valid);

  // fields: op3 sel2 off9 fix7 cri4 aqi2 moff9 msh9 msel1
  localparam int NROW = 12;
  localparam logic [45:0] TBL [NROW] = '{
    {3'd1, 2'd0, 9'd0,   7'd0,   4'd0,  2'd0, 9'd0,   9'd0, 1'b0}, // R4 R5
    {3'd1, 2'd1, 9'd450, 7'd0,   4'd0,  2'd0, 9'd0,   9'd0, 1'b0}, // R4 wrap
    {3'd1, 2'd2, 9'd100, 7'd0,   4'd0,  2'd0, 9'd0,   9'd0, 1'b0}, // R5 bypass
    {3'd1, 2'd3, 9'd7,   7'd0,   4'd0,  2'd0, 9'd0,   9'd0, 1'b0}, // R5 code 3
    {3'd2, 2'd0, 9'd400, 7'd5,   4'd0,  2'd0, 9'd0,   9'd0, 1'b0}, // R6 pad
    {3'd2, 2'd1, 9'd0,   7'd127, 4'd0,  2'd0, 9'd0,   9'd0, 1'b0}, // R6
    {3'd3, 2'd0, 9'd511, 7'd0,   4'd3,  2'd0, 9'd0,   9'd0, 1'b0}, // R7 pad
    {3'd3, 2'd0, 9'd384, 7'd0,   4'd15, 2'd0, 9'd0,   9'd0, 1'b0}, // R7 last in range
    {3'd4, 2'd0, 9'd385, 7'd0,   4'd0,  2'd2, 9'd0,   9'd0, 1'b0}, // R8 pad
    {3'd1, 2'd0, 9'd9,   7'd0,   4'd0,  2'd0, 9'd0,   9'd0, 1'b1}, // R9 pattern
    {3'd3, 2'd0, 9'd20,  7'd0,   4'd7,  2'd0, 9'd500, 9'd0, 1'b0}, // R9 end of mask
    {3'd2, 2'd2, 9'd60,  7'd64,  4'd0,  2'd0, 9'd3,   9'd7, 1'b1}  // R9 shift
  };

  function automatic logic [7:0] vb(logic [1023:0] v, int k);
    return v[k*8 +: 8];
  endfunction

  function automatic int model(int i);
    int a, b, lin, mi;
    logic [1023:0] mc;
    lin = cyc_off + i;
    mi  = mask_off + mask_shift + i;
    mc  = (src_sel == 0) ? r0_vec : (src_sel == 1) ? r1_vec : byp_vec;
    if (mi >= 512 || !mask_reg[mi]) return 0;
    case (op)
      3'd1: begin a = $signed(vb(mc, i)); b = $signed(cyc_reg[(lin % 512)*8 +: 8]); end
      3'd2: begin a = $signed(vb(mc, fix_idx)); b = (lin < 512) ? $signed(cyc_reg[lin*8 +: 8]) : 1; end
      3'd3: begin a = $signed(cr_regs[cr_idx*32 +: 8]); b = (lin < 512) ? $signed(cyc_reg[lin*8 +: 8]) : 1; end
      3'd4: begin a = $signed(aq_regs[aq_idx*32 +: 8]); b = (lin < 512) ? $signed(cyc_reg[lin*8 +: 8]) : 1; end
      default: return 0;
    endcase
    return a * b;
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s valid act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic check_vec(string req, bit expect_zero);
    int bad = -1;
    int e = 0;
    checks++;
    for (int i = 0; i < 128; i++) begin
      int x = expect_zero ? 0 : model(i);
      if (bad < 0 && prod_vec[i*32 +: 32] !== 32'(x)) begin bad = i; e = x; end
    end
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s lane %0d act=%0h exp=%0h", req, bad, prod_vec[bad*32 +: 32], 32'(e));
    end
  endtask

  task automatic apply_row(logic [45:0] r);
    {op, src_sel, cyc_off, fix_idx, cr_idx, aq_idx, mask_off, mask_shift} = r[45:1];
    for (int k = 0; k < 512; k++) mask_reg[k] = r[0] ? ((k % 3) != 0) : 1'b1;
  endtask

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd1: return "R4/R5/R9/R10";
      3'd2: return "R6/R9/R10";
      3'd3: return "R7/R9/R10";
      default: return "R8/R9/R10";
    endcase
  endfunction

  initial begin
    for (int k = 0; k < 128; k++) begin
      r0_vec[k*8 +: 8]  = 8'(k*3 + 1);
      r1_vec[k*8 +: 8]  = 8'(200 - k*5);
      byp_vec[k*8 +: 8] = 8'(k) ^ 8'h5A;
    end
    for (int k = 0; k < 512; k++) cyc_reg[k*8 +: 8] = 8'(k*7 + 3);
    for (int j = 0; j < 16; j++) cr_regs[j*32 +: 32] = 32'h1234_5600 | 32'(8'(j*9 - 40));
    for (int j = 0; j < 4; j++) aq_regs[j*32 +: 32] = 32'hABCD_0000 | 32'(8'(j*37 - 70));
    op = 3'd1; src_sel = 0; cyc_off = 0; fix_idx = 0; cr_idx = 0; aq_idx = 0;
    mask_reg = '1; mask_off = 0; mask_shift = 0;

    repeat (3) @(negedge clk);
    check_bit("R1", prod_valid, 1'b0);       // R1 during reset
    check_vec("R1", 1'b1);
    rst_n = 1'b1;
    op = 3'd0;
    @(negedge clk);
    check_bit("R1", prod_valid, 1'b0);       // R1 first sample after reset
    check_vec("R1", 1'b1);

    for (int r = 0; r < NROW; r++) begin
      apply_row(TBL[r]);
      @(negedge clk);
      check_bit("R2", prod_valid, 1'b1);
      check_vec(req_of(TBL[r][45:43]), 1'b0);
    end

    op = 3'd0;                               // R2 one cycle only, R3 idle zero
    @(negedge clk);
    check_bit("R2", prod_valid, 1'b0);
    check_vec("R3", 1'b1);

    op = 3'd6; cyc_off = 9'd5;               // R2 unused code acts as no-op
    @(negedge clk);
    check_bit("R2", prod_valid, 1'b0);
    check_vec("R3", 1'b1);

    aq_regs[32 +: 8] = 8'h80;                // R10 negative scalar sign extension
    op = 3'd4; aq_idx = 2'd1; cyc_off = 9'd0; mask_reg = '1; mask_off = 0; mask_shift = 0;
    @(negedge clk);
    checks++;
    if (prod_vec[31:0] !== 32'hFFFF_FE80) begin  // -128 * 3
      fails++;
      $display("FAIL R10 lane 0 act=%0h exp=%0h", prod_vec[31:0], 32'hFFFF_FE80);
    end
    check_vec("R8/R10", 1'b0);

    mask_reg = '0; op = 3'd1;                // R9 empty mask
    @(negedge clk);
    check_bit("R2", prod_valid, 1'b1);
    check_vec("R9", 1'b1);

    mask_reg = '1; op = 3'd3;                // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_bit("R1", prod_valid, 1'b0);
    check_vec("R1", 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    op = 3'd0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule